// File: doc/BRIEF.md
# Free-Running Timer with Capture and Compare

This block is a 16-bit up-counter that advances on one of three prescaled clock enables or on rising edges of an external clock pin. A control byte picks the count source. Four capture channels latch the counter when their pin shows the chosen edge. Each channel can watch for a rising or a falling edge. A compare register raises a match flag when the count steps off the compare value, and it can optionally send the counter back to zero there. A rollover from the all-ones count to zero raises an overflow flag.

Software reaches every register through a single-cycle 8-bit port. A read returns data in the same cycle. A write takes effect at the next clock edge. Status flags can only be set by hardware. A flag can be cleared only by a read that returns it as 1, followed later by a write of 0 to that bit. Channels A and B can each be put into a buffered mode. In that mode a capture first moves the previous value into channel C or D, then loads the new count. An interrupt request is raised while any flag is set.

Top module: `frt_capcmp`

## Requirements
- R1: After reset the counter, compare register, control byte (addr 4), status byte (addr 5) and capture registers all read 0x00, and irq_o is 0.
- R2: Control bits [1:0] select the count source: 00 uses tick_div_i[0], 01 uses tick_div_i[1], 10 uses tick_div_i[2], and 11 uses rising edges of ext_clk_i after a two-flop synchronizer. The unselected sources do not move the counter.
- R3: Overflow status bit 1 (ovf_flag_o) sets when a counting step takes the counter from 0xFFFF to 0x0000.
- R4: Status bits 1 (overflow), 2 (compare) and 7..4 (capture D,C,B,A) are changed by software only as follows: writing 1 to a bit has no effect, writing 0 to a bit has no effect unless an earlier read returned that bit as 1, and writing 0 after such a read clears the bit. Bit 0 is a plain read/write counter-clear enable.
- R5: A counting step taken while the counter equals the compare register (addresses 2 and 3, high byte first) sets the compare flag (status bit 2). If status bit 0 is 1, that step loads 0 instead of incrementing and does not set the overflow flag.
- R6: Control bits 7, 6, 5 and 4 set the capture edge of channels A, B, C and D (0 means falling, 1 means rising). On a synchronized edge of the chosen polarity, the channel register loads the counter value and its status flag sets. An edge of the opposite polarity changes neither.
- R7: Control bit 3 (bit 2) puts channel A (B) into buffered mode. A capture on A (B) copies the old A (B) value into C (D) and loads the counter into A (B). The C (D) pin then captures nothing and does not set its flag.
- R8: If a flag-setting event and a clearing write land in the same cycle, the flag stays set, and a new read of 1 is needed before a later write of 0 can clear it.
- R9: irq_o is 1 exactly when at least one status flag is set.
- R10: Counter bytes are written at address 0 (high) and 1 (low). A write in the same cycle as a counting step loads the written byte, and that step neither increments nor raises an event. Capture registers read at addresses 6 to 13 as high/low byte pairs for A, B, C, D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_div_i | input | 3 | Prescaled count enables: divide-by-2, by-8, by-32 |
| ext_clk_i | input | 1 | External count clock, asynchronous |
| cap_pin_i | input | 4 | Capture pins for channels A..D (bit 0 is A), asynchronous |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | 4 | Register byte address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid in the access cycle |
| cap_a_o | output | 16 | Capture register A |
| cap_b_o | output | 16 | Capture register B |
| cap_c_o | output | 16 | Capture register C |
| cap_d_o | output | 16 | Capture register D |
| cap_flag_o | output | 4 | Capture flags A..D (bit 0 is A) |
| cmp_flag_o | output | 1 | Compare-match flag |
| ovf_flag_o | output | 1 | Overflow flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a rollover that lands in the very cycle a clearing write arrives for an overflow flag that is already armed. The stimulus builds this in steps. It raises the overflow flag, reads it to arm the clear, and then writes the counter to 0xFFFF. It then issues the clearing write to the status byte in the same cycle as a single counting enable pulse. To make the captures and the compare step predictable, the enables are driven one pulse at a time, and the counter is held still while capture pins toggle.

// File: rtl/frt_pkg.sv
package frt_pkg;
    localparam int unsigned BUS_W  = 8;
    localparam int unsigned CNT_W  = 2 * BUS_W;
    localparam int unsigned ADDR_W = 4;
    localparam int unsigned N_CAP  = 4;
    localparam int unsigned N_PAIR = N_CAP / 2;
    localparam int unsigned N_DIV  = 3;
    localparam int unsigned FLAG_W = BUS_W - 1;

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    localparam logic [ADDR_W-1:0] AD_CNT_HI   = 4'd0;
    localparam logic [ADDR_W-1:0] AD_CNT_LO   = 4'd1;
    localparam logic [ADDR_W-1:0] AD_CMP_HI   = 4'd2;
    localparam logic [ADDR_W-1:0] AD_CMP_LO   = 4'd3;
    localparam logic [ADDR_W-1:0] AD_CTRL     = 4'd4;
    localparam logic [ADDR_W-1:0] AD_STAT     = 4'd5;
    localparam logic [ADDR_W-1:0] AD_CAP_BASE = 4'd6;

    localparam int unsigned CTRL_EDGE_MSB = 7;
    localparam int unsigned CTRL_BUF_MSB  = 3;
    localparam int unsigned STAT_CCLR_BIT = 0;

    typedef enum logic [1:0] {
        SRC_DIV2  = 2'b00,
        SRC_DIV8  = 2'b01,
        SRC_DIV32 = 2'b10,
        SRC_EXT   = 2'b11
    } cnt_src_e;
endpackage

// File: rtl/frt_sync.sv
module frt_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] prev_o
);
    logic [STAGES:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[STAGES-1:0], async_i};
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= pipe_d;
    end

    assign sync_o = pipe_q[STAGES-1];
    assign prev_o = pipe_q[STAGES];
endmodule

// File: rtl/frt_tick_sel.sv
module frt_tick_sel
    import frt_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [N_DIV-1:0] div_en_i,
    input  logic             ext_clk_i,
    input  logic [1:0]       src_i,
    output logic             tick_o
);
    logic ext_sync, ext_prev, ext_rise;

    frt_sync #(.W(1), .STAGES(SYNC_STAGES)) ext_sync_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (ext_clk_i),
        .sync_o  (ext_sync),
        .prev_o  (ext_prev)
    );

    assign ext_rise = ext_sync && !ext_prev;

    always_comb begin
        unique case (cnt_src_e'(src_i))
            SRC_DIV2:  tick_o = div_en_i[0];
            SRC_DIV8:  tick_o = div_en_i[1];
            SRC_DIV32: tick_o = div_en_i[2];
            default:   tick_o = ext_rise;
        endcase
    end
endmodule

// File: rtl/frt_flag_bank.sv
module frt_flag_bank #(
    parameter int unsigned W = 7
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] set_i,
    input  logic         rd_i,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] flag_o
);
    typedef struct packed {
        logic flag;
        logic arm;
    } bit_state_t;

    for (genvar g = 0; g < W; g++) begin : g_bit
        bit_state_t st_d, st_q;

        always_comb begin
            st_d = st_q;
            if (rd_i && st_q.flag) st_d.arm = 1'b1;
            if (wr_i && !wdata_i[g] && st_q.arm) begin
                st_d.flag = 1'b0;
                st_d.arm  = 1'b0;
            end
            if (set_i[g]) st_d.flag = 1'b1;
        end

        always_ff @(posedge clk_i) begin
            if (!rst_ni) st_q <= '0;
            else         st_q <= st_d;
        end

        assign flag_o[g] = st_q.flag;
    end
endmodule

// File: rtl/frt_capcmp.sv
module frt_capcmp
    import frt_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [N_DIV-1:0]  tick_div_i,
    input  logic              ext_clk_i,
    input  logic [N_CAP-1:0]  cap_pin_i,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [BUS_W-1:0]  bus_wdata_i,
    output logic [BUS_W-1:0]  bus_rdata_o,
    output logic [CNT_W-1:0]  cap_a_o,
    output logic [CNT_W-1:0]  cap_b_o,
    output logic [CNT_W-1:0]  cap_c_o,
    output logic [CNT_W-1:0]  cap_d_o,
    output logic [N_CAP-1:0]  cap_flag_o,
    output logic              cmp_flag_o,
    output logic              ovf_flag_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [CNT_W-1:0]            cnt;
        logic [CNT_W-1:0]            cmp;
        logic [BUS_W-1:0]            ctrl;
        logic                        cclr;
        logic [N_CAP-1:0][CNT_W-1:0] cap;
    } state_t;

    state_t s_d, s_q;

    logic              tick;
    logic              rd_en, wr_en, cnt_wr, stat_rd, stat_wr;
    logic              cmp_ev, clr_match, ovf_ev;
    logic [N_CAP-1:0]  pin_sync, pin_prev, edge_ev, cap_eff;
    logic [N_PAIR-1:0] buffered;
    logic [FLAG_W-1:0] flag_set, flags;
    logic [ADDR_W-1:0] cap_off;

    // names seen by the bound checker
    logic [CNT_W-1:0]  cnt_q, cmp_q;
    logic [BUS_W-1:0]  ctrl_q;
    logic              cclr_q;

    frt_tick_sel #(.SYNC_STAGES(SYNC_STAGES)) tick_sel_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .div_en_i  (tick_div_i),
        .ext_clk_i (ext_clk_i),
        .src_i     (s_q.ctrl[1:0]),
        .tick_o    (tick)
    );

    frt_sync #(.W(N_CAP), .STAGES(SYNC_STAGES)) pin_sync_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (cap_pin_i),
        .sync_o  (pin_sync),
        .prev_o  (pin_prev)
    );

    always_comb begin
        s_d     = s_q;
        rd_en   = bus_sel_i && !bus_wr_i;
        wr_en   = bus_sel_i && bus_wr_i;
        stat_rd = rd_en && (bus_addr_i == AD_STAT);
        stat_wr = wr_en && (bus_addr_i == AD_STAT);
        cnt_wr  = wr_en && ((bus_addr_i == AD_CNT_HI) || (bus_addr_i == AD_CNT_LO));

        // counting step and its events
        cmp_ev    = tick && !cnt_wr && (s_q.cnt == s_q.cmp);
        clr_match = cmp_ev && s_q.cclr;
        ovf_ev    = tick && !cnt_wr && !clr_match && (s_q.cnt == CNT_MAX);

        if (cnt_wr) begin
            if (bus_addr_i == AD_CNT_HI) s_d.cnt[CNT_W-1:BUS_W] = bus_wdata_i;
            else                         s_d.cnt[BUS_W-1:0]     = bus_wdata_i;
        end else if (tick) begin
            s_d.cnt = clr_match ? '0 : s_q.cnt + CNT_ONE;
        end

        // control registers
        if (wr_en) begin
            case (bus_addr_i)
                AD_CMP_HI: s_d.cmp[CNT_W-1:BUS_W] = bus_wdata_i;
                AD_CMP_LO: s_d.cmp[BUS_W-1:0]     = bus_wdata_i;
                AD_CTRL:   s_d.ctrl               = bus_wdata_i;
                AD_STAT:   s_d.cclr               = bus_wdata_i[STAT_CCLR_BIT];
                default: ;
            endcase
        end

        // capture edges, polarity per channel
        for (int i = 0; i < N_CAP; i++) begin
            edge_ev[i] = s_q.ctrl[CTRL_EDGE_MSB - i] ? (pin_sync[i] && !pin_prev[i])
                                                     : (!pin_sync[i] && pin_prev[i]);
        end

        cap_eff = edge_ev;
        for (int i = 0; i < N_PAIR; i++) begin
            buffered[i] = s_q.ctrl[CTRL_BUF_MSB - i];
            if (buffered[i]) cap_eff[i + N_PAIR] = 1'b0;
        end

        for (int i = 0; i < N_CAP; i++) begin
            if (cap_eff[i]) s_d.cap[i] = s_q.cnt;
        end
        for (int i = 0; i < N_PAIR; i++) begin
            if (buffered[i] && cap_eff[i]) s_d.cap[i + N_PAIR] = s_q.cap[i];
        end

        flag_set = {cap_eff, 1'b0, cmp_ev, ovf_ev};
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    frt_flag_bank #(.W(FLAG_W)) flag_bank_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .set_i   (flag_set),
        .rd_i    (stat_rd),
        .wr_i    (stat_wr),
        .wdata_i (bus_wdata_i[BUS_W-1:1]),
        .flag_o  (flags)
    );

    // read port, same-cycle data
    always_comb begin
        bus_rdata_o = '0;
        cap_off     = bus_addr_i - AD_CAP_BASE;
        case (bus_addr_i)
            AD_CNT_HI: bus_rdata_o = s_q.cnt[CNT_W-1:BUS_W];
            AD_CNT_LO: bus_rdata_o = s_q.cnt[BUS_W-1:0];
            AD_CMP_HI: bus_rdata_o = s_q.cmp[CNT_W-1:BUS_W];
            AD_CMP_LO: bus_rdata_o = s_q.cmp[BUS_W-1:0];
            AD_CTRL:   bus_rdata_o = s_q.ctrl;
            AD_STAT:   bus_rdata_o = {flags, s_q.cclr};
            default: begin
                for (int i = 0; i < N_CAP; i++) begin
                    if (cap_off == ADDR_W'(2 * i))
                        bus_rdata_o = s_q.cap[i][CNT_W-1:BUS_W];
                    if (cap_off == ADDR_W'(2 * i + 1))
                        bus_rdata_o = s_q.cap[i][BUS_W-1:0];
                end
            end
        endcase
    end

    assign cnt_q      = s_q.cnt;
    assign cmp_q      = s_q.cmp;
    assign ctrl_q     = s_q.ctrl;
    assign cclr_q     = s_q.cclr;
    assign cap_a_o    = s_q.cap[0];
    assign cap_b_o    = s_q.cap[1];
    assign cap_c_o    = s_q.cap[2];
    assign cap_d_o    = s_q.cap[3];
    assign ovf_flag_o = flags[0];
    assign cmp_flag_o = flags[1];
    assign cap_flag_o = flags[FLAG_W-1:FLAG_W-N_CAP];
    assign irq_o      = |flags;
endmodule

// File: rtl/frt_capcmp_chk.sv
module frt_capcmp_chk
    import frt_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              bus_sel_i,
    input logic              bus_wr_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [BUS_W-1:0]  bus_wdata_i,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [CNT_W-1:0]  cmp_q,
    input logic [BUS_W-1:0]  ctrl_q,
    input logic              cclr_q,
    input logic [CNT_W-1:0]  cap_a_o,
    input logic [CNT_W-1:0]  cap_b_o,
    input logic [CNT_W-1:0]  cap_c_o,
    input logic [CNT_W-1:0]  cap_d_o,
    input logic [N_CAP-1:0]  cap_flag_o,
    input logic              ovf_flag_o
);
    logic cnt_wr, stat_wr;
    assign cnt_wr  = bus_sel_i && bus_wr_i && ((bus_addr_i == AD_CNT_HI) || (bus_addr_i == AD_CNT_LO));
    assign stat_wr = bus_sel_i && bus_wr_i && (bus_addr_i == AD_STAT);

    // R2
    cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cnt_wr |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CNT_ONE || cnt_q == '0));

    // R5
    cmp_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cclr_q && cnt_q == cmp_q && !cnt_wr) |=> (cnt_q == '0 || $stable(cnt_q)));

    // R3
    ovf_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ovf_flag_o) |-> ($past(cnt_q) == CNT_MAX && cnt_q == '0));

    // R4
    ovf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ovf_flag_o && !stat_wr) |=> ovf_flag_o);

    // R4
    no_sw_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stat_wr && bus_wdata_i[1] && !ovf_flag_o && cnt_q != CNT_MAX) |=> !ovf_flag_o);

    // R4
    cap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !stat_wr |=> ((cap_flag_o & $past(cap_flag_o)) == $past(cap_flag_o)));

    // R7
    buf_ac_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctrl_q[3] |=> ($stable(cap_c_o) || cap_c_o == $past(cap_a_o)));

    // R7
    buf_bd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctrl_q[2] |=> ($stable(cap_d_o) || cap_d_o == $past(cap_b_o)));
endmodule

bind frt_capcmp frt_capcmp_chk chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_sel_i   (bus_sel_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .cnt_q       (cnt_q),
    .cmp_q       (cmp_q),
    .ctrl_q      (ctrl_q),
    .cclr_q      (cclr_q),
    .cap_a_o     (cap_a_o),
    .cap_b_o     (cap_b_o),
    .cap_c_o     (cap_c_o),
    .cap_d_o     (cap_d_o),
    .cap_flag_o  (cap_flag_o),
    .ovf_flag_o  (ovf_flag_o)
);

// File: tb/frt_capcmp_tb_top.sv
`timescale 1ns/1ps
module frt_capcmp_tb_top;
    localparam logic [3:0] A_CNTH = 4'd0, A_CNTL = 4'd1, A_CMPH = 4'd2, A_CMPL = 4'd3;
    localparam logic [3:0] A_CTRL = 4'd4, A_STAT = 4'd5;
    localparam logic [3:0] A_CAPAH = 4'd6, A_CAPAL = 4'd7, A_CAPBL = 4'd9;
    localparam logic [3:0] A_CAPCH = 4'd10, A_CAPCL = 4'd11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  tick_div = '0;
    logic        ext_clk = 1'b0;
    logic [3:0]  cap_pin = '0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [15:0] cap_a, cap_b, cap_c, cap_d;
    logic [3:0]  cap_flag;
    logic        cmp_flag, ovf_flag, irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } exp_t;
    exp_t sb_q[$];
    exp_t mon_item;

    always #2.5 clk = ~clk;

    frt_capcmp dut_i (
        .clk_i(clk), .rst_ni(rst_n), .tick_div_i(tick_div), .ext_clk_i(ext_clk),
        .cap_pin_i(cap_pin), .bus_sel_i(bus_sel), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .cap_a_o(cap_a), .cap_b_o(cap_b),
        .cap_c_o(cap_c), .cap_d_o(cap_d), .cap_flag_o(cap_flag), .cmp_flag_o(cmp_flag),
        .ovf_flag_o(ovf_flag), .irq_o(irq)
    );

    // monitor: pops expected read data and compares in the read cycle
    always @(negedge clk) begin
        if (rst_n && bus_sel && !bus_wr && sb_q.size() > 0) begin
            mon_item = sb_q.pop_front();
            checks++;
            if (bus_rdata !== mon_item.exp) begin
                errors++;
                $display("FAIL %s: read %h expected %h", mon_item.tag, bus_rdata, mon_item.exp);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr_tick(input logic [3:0] a, input logic [7:0] d, input logic [2:0] t);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick_div = t;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0; tick_div = '0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        wr_tick(a, d, 3'b000);
    endtask

    task automatic expect_rd(input logic [3:0] a, input logic [7:0] e, input string tag);
        exp_t it;
        it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic expect_cnt(input logic [15:0] v, input string tag);
        expect_rd(A_CNTH, v[15:8], tag);
        expect_rd(A_CNTL, v[7:0], tag);
    endtask

    task automatic set_cnt(input logic [15:0] v);
        wr(A_CNTH, v[15:8]);
        wr(A_CNTL, v[7:0]);
    endtask

    task automatic pulse(input logic [2:0] m, input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1; tick_div = m;
            @(posedge clk); #1; tick_div = '0;
        end
    endtask

    task automatic check_sig(input logic [15:0] act, input logic [15:0] e, input string tag);
        checks++;
        if (act !== e) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, e);
        end
    endtask

    task automatic finish_sim();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, got timeout expected completion");
        finish_sim();
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        expect_rd(A_CTRL, 8'h00, "R1 ctrl");
        expect_rd(A_STAT, 8'h00, "R1 stat");
        expect_cnt(16'h0000, "R1 counter");
        expect_rd(A_CMPL, 8'h00, "R1 compare");
        expect_rd(A_CAPAH, 8'h00, "R1 capture");
        check_sig(16'(irq), 16'd0, "R1 irq");

        // R10 counter write, write beats a counting step
        set_cnt(16'h1234);
        expect_cnt(16'h1234, "R10 counter write");
        wr_tick(A_CNTL, 8'h40, 3'b001);
        expect_cnt(16'h1240, "R10 write over tick");

        // R2 clock source select
        pulse(3'b001, 3);
        expect_cnt(16'h1243, "R2 div2 source");
        pulse(3'b010, 2);
        pulse(3'b100, 1);
        expect_cnt(16'h1243, "R2 unselected enables");
        wr(A_CTRL, 8'h01);
        pulse(3'b010, 1);
        pulse(3'b001, 1);
        expect_cnt(16'h1244, "R2 div8 source");
        wr(A_CTRL, 8'h02);
        pulse(3'b100, 1);
        pulse(3'b010, 1);
        expect_cnt(16'h1245, "R2 div32 source");
        wr(A_CTRL, 8'h03);
        ext_clk = 1'b1; idle(5);
        ext_clk = 1'b0; idle(5);
        ext_clk = 1'b1; idle(5);
        pulse(3'b111, 1);
        expect_cnt(16'h1247, "R2 external rising edges");
        ext_clk = 1'b0; idle(5);
        wr(A_CTRL, 8'h00);

        // R3 overflow
        set_cnt(16'hFFFE);
        pulse(3'b001, 1);
        check_sig(16'(ovf_flag), 16'd0, "R3 no overflow at FFFF");
        pulse(3'b001, 1);
        check_sig(16'(ovf_flag), 16'd1, "R3 overflow on rollover");
        check_sig(16'(irq), 16'd1, "R9 irq with overflow");
        expect_cnt(16'h0000, "R3 counter after rollover");

        // R4 clearing handshake
        wr(A_STAT, 8'h02);
        check_sig(16'(ovf_flag), 16'd1, "R4 write 1 no effect");
        wr(A_STAT, 8'h00);
        check_sig(16'(ovf_flag), 16'd1, "R4 write 0 without read");
        expect_rd(A_STAT, 8'h02, "R4 status read");
        wr(A_STAT, 8'h00);
        check_sig(16'(ovf_flag), 16'd0, "R4 cleared after read");
        check_sig(16'(irq), 16'd0, "R9 irq low with no flags");

        // R5 compare without clear
        wr(A_CMPH, 8'h00);
        wr(A_CMPL, 8'h10);
        set_cnt(16'h000E);
        pulse(3'b001, 3);
        expect_cnt(16'h0011, "R5 count passes compare");
        check_sig(16'(cmp_flag), 16'd1, "R5 compare flag");
        expect_rd(A_STAT, 8'h04, "R5 status");
        wr(A_STAT, 8'h00);
        check_sig(16'(cmp_flag), 16'd0, "R4 compare flag cleared");
        // R5 compare with clear
        wr(A_STAT, 8'h01);
        set_cnt(16'h000E);
        pulse(3'b001, 3);
        expect_cnt(16'h0000, "R5 cleared on match");
        check_sig(16'(cmp_flag), 16'd1, "R5 compare flag with clear");
        check_sig(16'(ovf_flag), 16'd0, "R5 clear is not overflow");
        expect_rd(A_STAT, 8'h05, "R5 status with clear enable");
        wr(A_STAT, 8'h00);

        // R6 capture edge select
        set_cnt(16'h0ABC);
        cap_pin[0] = 1'b1; idle(5);
        expect_rd(A_CAPAL, 8'h00, "R6 rising ignored on falling channel");
        check_sig(16'(cap_flag), 16'h0, "R6 no flag on wrong edge");
        cap_pin[0] = 1'b0; idle(5);
        check_sig(cap_a, 16'h0ABC, "R6 falling capture A");
        check_sig(16'(cap_flag), 16'h1, "R6 flag A");
        expect_rd(A_CAPAH, 8'h0A, "R6 capture A high byte");
        wr(A_CTRL, 8'h40);
        set_cnt(16'h0BCD);
        cap_pin[1] = 1'b1; idle(5);
        set_cnt(16'h0BCE);
        cap_pin[1] = 1'b0; idle(5);
        expect_rd(A_CAPBL, 8'hCD, "R6 rising capture B");
        check_sig(16'(cap_flag), 16'h3, "R6 flag B");

        // R7 buffered channel A
        wr(A_CTRL, 8'h08);
        set_cnt(16'h0200);
        cap_pin[0] = 1'b1; idle(5);
        cap_pin[0] = 1'b0; idle(5);
        expect_rd(A_CAPCH, 8'h0A, "R7 old A moved to C");
        expect_rd(A_CAPCL, 8'hBC, "R7 old A moved to C");
        check_sig(cap_a, 16'h0200, "R7 new A value");
        set_cnt(16'h0300);
        cap_pin[2] = 1'b1; idle(5);
        cap_pin[2] = 1'b0; idle(5);
        check_sig(cap_c, 16'h0ABC, "R7 C pin ignored");
        check_sig(16'(cap_flag), 16'h3, "R7 no C flag");

        // R4 capture flags
        expect_rd(A_STAT, 8'h30, "R4 capture flags");
        wr(A_STAT, 8'h20);
        check_sig(16'(cap_flag), 16'h2, "R4 clear A keep B");

        // R8 set beats clear
        set_cnt(16'hFFFF);
        pulse(3'b001, 1);
        expect_rd(A_STAT, 8'h22, "R8 armed read");
        set_cnt(16'hFFFF);
        wr_tick(A_STAT, 8'h20, 3'b001);
        check_sig(16'(ovf_flag), 16'd1, "R8 set wins over clear");
        wr(A_STAT, 8'h20);
        check_sig(16'(ovf_flag), 16'd1, "R8 arm consumed");
        expect_rd(A_STAT, 8'h22, "R8 rearm read");
        wr(A_STAT, 8'h20);
        check_sig(16'(ovf_flag), 16'd0, "R8 cleared after rearm");

        idle(3);
        finish_sim();
    end
endmodule